// File: doc/BRIEF.md
# Wide-Operand FIR Tap Slice

This block is one tap of a transposed-form FIR filter built for wide samples. Two 26-bit signed samples are summed or differenced into a 27-bit operand. A mode bit can instead route a 27-bit direct sample to the multiplier. The chosen operand is multiplied by a 27-bit signed coefficient read from a small internal store of eight entries. The 54-bit signed product is sign-extended to 64 bits and added to a 64-bit running sum. Each slice forms exactly one tap and holds no systolic delay registers.

In normal use, the addend is the sum arriving from the previous slice on `chain_in`, and the registered sum leaves on `chain_out` for the next slice. Eleven slices can be cascaded, because the 10 guard bits above the product width absorb the growth of eleven full-scale products. Two other modes are available. An accumulate mode feeds the slice's own registered sum back as the addend. A synchronous clear zeros the sum. The coefficient store is loaded through a simple write port.

Top module: `wfir_slice`

## Requirements
- R1: While `rst` is high, `result` and `chain_out` read zero from the clock edge after `rst` is first sampled high.
- R2: With `use_x` = 0, the multiplier operand is the 27-bit sign-extended sum `in_y + in_z` when `pre_sub` = 0, and the 27-bit sign-extended difference `in_y - in_z` when `pre_sub` = 1.
- R3: The coefficient is the store entry addressed by `coef_sel`. A write (`coef_we` = 1 with `coef_waddr`, `coef_wdata`) updates the entry at the clock edge. A product formed in the same cycle as the write still uses the old value, and the new value applies from the next cycle on.
- R4: With `use_x` = 1, the operand is `in_x`, and `in_y`, `in_z` and `pre_sub` have no effect on the result.
- R5: With `clr` = 0 and `acc_en` = 0, `result` becomes `chain_in` plus the sign-extended product one clock edge after the inputs are presented (two's-complement, modulo 2^64).
- R6: With `clr` = 0 and `acc_en` = 1, `result` becomes its previous value plus the sign-extended product, and `chain_in` is ignored.
- R7: `clr` = 1 zeros `result` at the next edge, overriding `acc_en` and `chain_in`.
- R8: `chain_out` carries the same value as `result` in every cycle.
- R9: Eleven slices chained `chain_out` to `chain_in`, with shared samples, produce at the last slice the exact convolution (sum over k of c[10-k]·s[n-k]) with no overflow, including full-scale operands of -2^26 and coefficients of -2^26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sum register |
| clr | input | 1 | Synchronous clear of the sum |
| acc_en | input | 1 | 1: add into own sum; 0: add into `chain_in` |
| pre_sub | input | 1 | Pre-adder: 0 adds, 1 subtracts `in_z` from `in_y` |
| use_x | input | 1 | 1: multiply `in_x`; 0: multiply the pre-adder output |
| coef_sel | input | 3 | Coefficient store read address |
| coef_we | input | 1 | Coefficient store write enable |
| coef_waddr | input | 3 | Coefficient store write address |
| coef_wdata | input | 27 | Signed coefficient to write |
| in_y | input | 26 | Signed pre-adder sample A |
| in_z | input | 26 | Signed pre-adder sample B |
| in_x | input | 27 | Signed direct multiplier sample |
| chain_in | input | 64 | Signed sum from the previous slice |
| result | output | 64 | Registered signed sum |
| chain_out | output | 64 | Registered signed sum to the next slice |

## Verification
Two pairs of functions can act in the same cycle. In the first, a coefficient write lands on the address being read, so the product must use the old entry while the store takes the new one. In the second, clear and accumulate are raised together with a nonzero chain input, and the clear must win. Both are provoked by directed cycles and also arise in a seeded random run. The bench judges each one against a cycle model that computes the product from the coefficient values held before the write and applies clear ahead of the addend choice.

// File: rtl/wfir_pkg.sv
`timescale 1ns/1ps
package wfir_pkg;
  localparam int unsigned SAMPLE_W_DEF = 26;
  localparam int unsigned MULX_W_DEF   = 27;
  localparam int unsigned COEF_W_DEF   = 27;
  localparam int unsigned SUM_W_DEF    = 64;
  localparam int unsigned SEL_W_DEF    = 3;

  typedef enum logic [1:0] {
    SUM_FROM_CHAIN = 2'd0,
    SUM_FROM_SELF  = 2'd1,
    SUM_CLEAR      = 2'd2
  } sum_src_e;
endpackage

// File: rtl/wfir_preadd.sv
`timescale 1ns/1ps
module wfir_preadd #(
  parameter int unsigned SAMPLE_W = 26,
  parameter int unsigned MULX_W   = 27,
  parameter int unsigned OP_W     = 27
) (
  input  logic signed [SAMPLE_W-1:0] y,
  input  logic signed [SAMPLE_W-1:0] z,
  input  logic                       sub,
  input  logic                       use_x,
  input  logic signed [MULX_W-1:0]   x,
  output logic signed [OP_W-1:0]     op
);
  localparam int unsigned PRE_W = SAMPLE_W + 1;

  logic signed [PRE_W-1:0] y_e, z_e, pa;

  always_comb begin
    y_e = PRE_W'(y);
    z_e = PRE_W'(z);
    pa  = sub ? (y_e - z_e) : (y_e + z_e);
    op  = use_x ? OP_W'(x) : OP_W'(pa);
  end
endmodule

// File: rtl/wfir_coef_bank.sv
`timescale 1ns/1ps
module wfir_coef_bank #(
  parameter int unsigned COEF_W = 27,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [SEL_W-1:0]         waddr,
  input  logic signed [COEF_W-1:0] wdata,
  input  logic [SEL_W-1:0]         sel,
  output logic signed [COEF_W-1:0] coef
);
  localparam int unsigned DEPTH = 1 << SEL_W;

  logic signed [COEF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign coef = mem[sel];
endmodule

// File: rtl/wfir_mul.sv
`timescale 1ns/1ps
module wfir_mul #(
  parameter int unsigned OP_W   = 27,
  parameter int unsigned COEF_W = 27,
  parameter int unsigned PROD_W = OP_W + COEF_W
) (
  input  logic signed [OP_W-1:0]   a,
  input  logic signed [COEF_W-1:0] b,
  output logic signed [PROD_W-1:0] p
);
  assign p = PROD_W'(a) * PROD_W'(b);
endmodule

// File: rtl/wfir_chain_acc.sv
`timescale 1ns/1ps
module wfir_chain_acc
  import wfir_pkg::*;
#(
  parameter int unsigned PROD_W = 54,
  parameter int unsigned SUM_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  sum_src_e                 src,
  input  logic signed [PROD_W-1:0] prod,
  input  logic signed [SUM_W-1:0]  chain_in,
  output logic signed [SUM_W-1:0]  sum_q
);
  logic signed [SUM_W-1:0] prod_e;
  logic signed [SUM_W-1:0] addend;

  always_comb begin
    prod_e = SUM_W'(prod);
    addend = (src == SUM_FROM_SELF) ? sum_q : chain_in;
  end

  always_ff @(posedge clk) begin
    if (rst || src == SUM_CLEAR) sum_q <= '0;
    else                         sum_q <= addend + prod_e;
  end
endmodule

// File: rtl/wfir_slice.sv
`timescale 1ns/1ps
module wfir_slice
  import wfir_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned MULX_W   = MULX_W_DEF,
  parameter int unsigned COEF_W   = COEF_W_DEF,
  parameter int unsigned SUM_W    = SUM_W_DEF,
  parameter int unsigned SEL_W    = SEL_W_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       acc_en,
  input  logic                       pre_sub,
  input  logic                       use_x,
  input  logic [SEL_W-1:0]           coef_sel,
  input  logic                       coef_we,
  input  logic [SEL_W-1:0]           coef_waddr,
  input  logic signed [COEF_W-1:0]   coef_wdata,
  input  logic signed [SAMPLE_W-1:0] in_y,
  input  logic signed [SAMPLE_W-1:0] in_z,
  input  logic signed [MULX_W-1:0]   in_x,
  input  logic signed [SUM_W-1:0]    chain_in,
  output logic signed [SUM_W-1:0]    result,
  output logic signed [SUM_W-1:0]    chain_out
);
  localparam int unsigned PRE_W  = SAMPLE_W + 1;
  localparam int unsigned OP_W   = (PRE_W > MULX_W) ? PRE_W : MULX_W;
  localparam int unsigned PROD_W = OP_W + COEF_W;

  logic signed [OP_W-1:0]   op_w;
  logic signed [COEF_W-1:0] coef_w;
  logic signed [PROD_W-1:0] prod_w;
  logic signed [SUM_W-1:0]  sum_w;
  sum_src_e                 src_w;

  always_comb begin
    if (clr)         src_w = SUM_CLEAR;
    else if (acc_en) src_w = SUM_FROM_SELF;
    else             src_w = SUM_FROM_CHAIN;
  end

  wfir_preadd #(.SAMPLE_W(SAMPLE_W), .MULX_W(MULX_W), .OP_W(OP_W)) u_pre (
    .y(in_y), .z(in_z), .sub(pre_sub), .use_x(use_x), .x(in_x), .op(op_w)
  );

  wfir_coef_bank #(.COEF_W(COEF_W), .SEL_W(SEL_W)) u_bank (
    .clk(clk), .we(coef_we), .waddr(coef_waddr), .wdata(coef_wdata),
    .sel(coef_sel), .coef(coef_w)
  );

  wfir_mul #(.OP_W(OP_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mul (
    .a(op_w), .b(coef_w), .p(prod_w)
  );

  wfir_chain_acc #(.PROD_W(PROD_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .src(src_w), .prod(prod_w),
    .chain_in(chain_in), .sum_q(sum_w)
  );

  assign result    = sum_w;
  assign chain_out = sum_w;
endmodule

// File: rtl/wfir_slice_chk.sv
`timescale 1ns/1ps
module wfir_slice_chk #(
  parameter int unsigned MULX_W = 27,
  parameter int unsigned COEF_W = 27,
  parameter int unsigned SUM_W  = 64,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned OP_W   = 27,
  parameter int unsigned PROD_W = 54
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     clr,
  input logic                     acc_en,
  input logic                     use_x,
  input logic [SEL_W-1:0]         coef_sel,
  input logic                     coef_we,
  input logic [SEL_W-1:0]         coef_waddr,
  input logic signed [COEF_W-1:0] coef_wdata,
  input logic signed [MULX_W-1:0] in_x,
  input logic signed [SUM_W-1:0]  chain_in,
  input logic signed [SUM_W-1:0]  result,
  input logic signed [OP_W-1:0]   op,
  input logic signed [COEF_W-1:0] coef,
  input logic signed [PROD_W-1:0] prod
);
  logic signed [SUM_W-1:0] pext;
  assign pext = SUM_W'(prod);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> result == '0); // R7

  AST_ACCUMULATE: assert property (@(posedge clk) disable iff (rst)
    (!clr && acc_en) |=> result == $past(result) + $past(pext)); // R6

  AST_CHAIN_SUM: assert property (@(posedge clk) disable iff (rst)
    (!clr && !acc_en) |=> result == $past(chain_in) + $past(pext)); // R5

  AST_X_OPERAND: assert property (@(posedge clk) disable iff (rst)
    use_x |-> op == OP_W'(in_x)); // R4

  AST_COEF_WRITE: assert property (@(posedge clk) disable iff (rst)
    coef_we ##1 (coef_sel == $past(coef_waddr)) |-> coef == $past(coef_wdata)); // R3
endmodule

bind wfir_slice wfir_slice_chk #(
  .MULX_W(MULX_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .SEL_W(SEL_W),
  .OP_W(OP_W), .PROD_W(PROD_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .acc_en(acc_en), .use_x(use_x),
  .coef_sel(coef_sel), .coef_we(coef_we), .coef_waddr(coef_waddr),
  .coef_wdata(coef_wdata), .in_x(in_x), .chain_in(chain_in),
  .result(result), .op(op_w), .coef(coef_w), .prod(prod_w)
);

// File: tb/wfir_slice_tb.sv
`timescale 1ns/1ps
module wfir_slice_tb;
  localparam int NST = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int bad    = 0;

  // single slice
  logic clr = 0, acc_en = 0, pre_sub = 0, use_x = 0, coef_we = 0;
  logic [2:0] coef_sel = 0, coef_waddr = 0;
  logic signed [26:0] coef_wdata = 0, in_x = 0;
  logic signed [25:0] in_y = 0, in_z = 0;
  logic signed [63:0] chain_in = 0, result, chain_out;

  wfir_slice u_dut (
    .clk(clk), .rst(rst), .clr(clr), .acc_en(acc_en), .pre_sub(pre_sub),
    .use_x(use_x), .coef_sel(coef_sel), .coef_we(coef_we),
    .coef_waddr(coef_waddr), .coef_wdata(coef_wdata), .in_y(in_y),
    .in_z(in_z), .in_x(in_x), .chain_in(chain_in), .result(result),
    .chain_out(chain_out)
  );

  // eleven-slice cascade
  logic c_clr = 0, c_sub = 0, c_ux = 0;
  logic [NST-1:0] c_we = '0;
  logic signed [26:0] c_wd [NST];
  logic signed [25:0] c_y = 0, c_z = 0;
  logic signed [26:0] c_x = 0;
  logic signed [63:0] ch [NST+1];
  logic signed [63:0] c_res [NST];
  assign ch[0] = '0;

  for (genvar g = 0; g < NST; g++) begin : g_st
    wfir_slice u_stage (
      .clk(clk), .rst(rst), .clr(c_clr), .acc_en(1'b0), .pre_sub(c_sub),
      .use_x(c_ux), .coef_sel(3'd0), .coef_we(c_we[g]), .coef_waddr(3'd0),
      .coef_wdata(c_wd[g]), .in_y(c_y), .in_z(c_z), .in_x(c_x),
      .chain_in(ch[g]), .result(c_res[g]), .chain_out(ch[g+1])
    );
  end

  // bench models
  logic signed [26:0] mmem [8];
  logic signed [63:0] exp_q = 0;
  logic signed [26:0] cc [NST];
  logic signed [26:0] sh [NST];

  function automatic logic signed [26:0] f_op(logic signed [25:0] y, logic signed [25:0] z,
                                             logic sub, logic ux, logic signed [26:0] x);
    logic signed [26:0] ye, ze;
    ye = 27'(y);
    ze = 27'(z);
    if (ux) return x;
    return sub ? (ye - ze) : (ye + ze);
  endfunction

  function automatic logic signed [63:0] f_mul(logic signed [26:0] a, logic signed [26:0] b);
    logic signed [63:0] ae, be;
    ae = 64'(a);
    be = 64'(b);
    return ae * be;
  endfunction

  function automatic logic signed [63:0] f_conv();
    logic signed [63:0] s;
    s = 0;
    for (int k = 0; k < NST; k++) s = s + f_mul(cc[NST-1-k], sh[k]);
    return s;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle of the single slice; inputs already set after a negedge
  task automatic step(string tag);
    logic signed [63:0] p, nxt;
    p = f_mul(f_op(in_y, in_z, pre_sub, use_x, in_x), mmem[coef_sel]);
    if (clr)         nxt = 0;
    else if (acc_en) nxt = exp_q + p;
    else             nxt = chain_in + p;
    if (coef_we) mmem[coef_waddr] = coef_wdata;
    @(negedge clk);
    exp_q = nxt;
    chk(tag, result, exp_q);
    chk("R8", chain_out, exp_q);
  endtask

  // one cycle of the cascade
  task automatic cstep(string tag);
    for (int k = NST-1; k > 0; k--) sh[k] = sh[k-1];
    sh[0] = f_op(c_y, c_z, c_sub, c_ux, c_x);
    if (c_clr) for (int k = 0; k < NST; k++) sh[k] = 0;
    for (int g = 0; g < NST; g++) if (c_we[g]) cc[g] = c_wd[g];
    @(negedge clk);
    chk(tag, ch[NST], f_conv());
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int g = 0; g < NST; g++) begin c_wd[g] = 0; cc[g] = 0; sh[g] = 0; end
    // reset, loading the coefficient stores meanwhile
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      coef_we = 1; coef_waddr = 3'(a); coef_wdata = 27'($urandom());
      mmem[a] = coef_wdata;
      @(negedge clk);
    end
    coef_we = 0;
    for (int g = 0; g < NST; g++) begin c_wd[g] = 27'($urandom()); cc[g] = c_wd[g]; end
    c_we = '1;
    @(negedge clk);
    c_we = '0;
    chk("R1", result, 0);
    chk("R1", chain_out, 0);
    chk("R1", ch[NST], 0);
    rst = 0;
    exp_q = 0;

    // R2 pre-adder add and subtract
    coef_sel = 3; in_y = 26'sd12345; in_z = -26'sd999; pre_sub = 0; step("R2");
    pre_sub = 1; step("R2");
    in_y = -26'sd33554432; in_z = 26'sd33554431; pre_sub = 1; step("R2");
    in_y = -26'sd33554432; in_z = -26'sd33554432; pre_sub = 0; step("R2");
    // R5 chain input plus product
    chain_in = 64'sh3000_0000_0000_0001; in_y = 26'sd7; in_z = 26'sd5; step("R5");
    chain_in = -64'sd1; step("R5");
    // R4 direct operand, y/z changed must not matter
    use_x = 1; in_x = -27'sd67108864; step("R4");
    in_y = 26'sd1; in_z = -26'sd77; pre_sub = 0; step("R4");
    use_x = 0;
    // R3 write colliding with read of the same entry
    coef_sel = 2; coef_we = 1; coef_waddr = 2; coef_wdata = -27'sd67108864; step("R3");
    coef_we = 0; step("R3");
    // R6 accumulate three cycles, chain input ignored
    acc_en = 1; chain_in = 64'sh7777_0000_0000_0000;
    step("R6"); step("R6"); step("R6");
    // R7 clear together with accumulate
    clr = 1; step("R7");
    clr = 0; acc_en = 0; step("R5");
    // R1 reset in mid run
    rst = 1; acc_en = 1; @(negedge clk);
    chk("R1", result, 0); chk("R1", chain_out, 0);
    rst = 0; exp_q = 0; acc_en = 0;

    // seeded random mix
    for (int i = 0; i < 400; i++) begin
      string tg;
      clr      = ($urandom() % 8) == 0;
      acc_en   = ($urandom() % 4) == 0;
      use_x    = ($urandom() % 3) == 0;
      pre_sub  = 1'($urandom());
      coef_sel = 3'($urandom());
      coef_we  = ($urandom() % 4) == 0;
      coef_waddr = ($urandom() % 2) ? coef_sel : 3'($urandom());
      coef_wdata = 27'($urandom());
      in_y = 26'($urandom()); in_z = 26'($urandom()); in_x = 27'($urandom());
      chain_in = {$urandom(), $urandom()};
      if (clr)          tg = "R7";
      else if (acc_en)  tg = "R6";
      else if (coef_we) tg = "R3";
      else if (use_x)   tg = "R4";
      else              tg = "R2";
      step(tg);
    end
    clr = 0; acc_en = 0; coef_we = 0;

    // R9 cascade: random coefficients, random samples
    c_clr = 1; cstep("R9"); c_clr = 0;
    for (int i = 0; i < 40; i++) begin
      c_ux = 1'($urandom()); c_sub = 1'($urandom());
      c_y = 26'($urandom()); c_z = 26'($urandom()); c_x = 27'($urandom());
      cstep("R9");
    end
    // R9 full scale: all coefficients -2^26, samples -2^26
    for (int g = 0; g < NST; g++) c_wd[g] = -27'sd67108864;
    c_we = '1; c_clr = 1; cstep("R9"); c_we = '0; c_clr = 0;
    c_ux = 0; c_sub = 0; c_y = -26'sd33554432; c_z = -26'sd33554432;
    for (int i = 0; i < 14; i++) cstep("R9");
    chk("R9", ch[NST], 64'sd11 * (64'sd1 <<< 52));
    // most negative total: positive samples against negative coefficients
    c_ux = 1; c_x = 27'sd67108863;
    for (int i = 0; i < 14; i++) cstep("R9");
    chk("R9", ch[NST], -64'sd11 * 64'sd67108863 * 64'sd67108864);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule